// File: doc/BRIEF.md
# Serial Conversion-Result Output Port

This block is the device-side end of a serial read-out link for a data converter. A parallel result word, 14 bits by default, is captured from a load strobe. When a host starts a frame, the word is moved into a shift register. It then leaves the device most significant bit first on a single data line, and a separate enable drives a three-state pad. The host supplies a serial clock and an active-low chip select. A frame-sync input lets a DSP-style host start the data phase on its own strobe.

All three host pins are brought into the system clock domain through synchronizer chains, and their edges are found there. At each detected falling edge of chip select the port looks at frame-sync. If frame-sync is high, the MSB is driven at once; this is the plain SPI-style case, and it is also the case when frame-sync is tied high. If frame-sync is low, the port waits, and the MSB appears only on the next rising edge of frame-sync.

Each later bit appears on a rising edge of the serial clock, so the host samples on falling edges. The pad is released either after the seventeenth rising clock edge of the frame or when chip select rises, whichever comes first.

Top module: `adcsdo_port`

## Requirements
- R1: After reset, and whenever the synchronized chip select is high, `sdo_oe_o` is 0. While `sdo_oe_o` is 0, `sdo_o` is 0.
- R2: At a detected chip-select falling edge where the synchronized frame-sync is 1, `sdo_oe_o` rises one cycle later and `sdo_o` carries frame bit 15.
- R3: At a detected chip-select falling edge where the synchronized frame-sync is 0, `sdo_oe_o` stays 0 until a frame-sync rising edge is detected, and serial-clock edges are ignored until then. After that edge the output is enabled with frame bit 15 on `sdo_o`.
- R4: The frame is 16 bits: bits 15..2 hold result bits 13..0 and bits 1..0 are 0. The bits leave most significant first.
- R5: While the output is enabled, `sdo_o` changes only in the cycle after a detected serial-clock rising edge. After the k-th such edge of the frame, `sdo_o` carries frame bit 15-k, and 0 once k reaches 16.
- R6: On the 17th detected serial-clock rising edge of a frame, `sdo_oe_o` falls. It stays 0 under further clocks until chip select goes high and a new frame starts.
- R7: A detected chip-select rising edge during a frame clears `sdo_oe_o` in the next cycle, even if fewer than 17 clocks were given.
- R8: `load_i` captures `result_i` into a holding word. A frame uses the holding word as it stood at the frame start, so a load during a frame changes only the next frame.
- R9: A load in the same cycle as the detected chip-select fall does not reach the frame that is starting. A chip-select rise in the same cycle as a serial-clock rise releases the pad, and that clock edge is not counted.
- R10: A pin level first sampled on a system clock edge acts on the outputs right after the SYNC_STAGES-th following edge, which is 2 with the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select from the host, active low, asynchronous |
| fs_i | input | 1 | Frame-sync from the host, asynchronous; tie high when unused |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| result_i | input | RESULT_W | Parallel conversion result |
| load_i | input | 1 | Captures result_i into the holding word |
| sdo_o | output | 1 | Serial data to the pad |
| sdo_oe_o | output | 1 | Drive enable for the three-state data pad |

## Verification
Two pairs of events can land in the same synchronized cycle. The first pair is a load of a new result and the detected fall of chip select. The second pair is a chip-select rise and a serial-clock rise. The bench provokes the first by placing the load strobe exactly the synchronizer delay after the chip-select pin drops, then reads the frame as a host and expects the older word, followed by the newer word in the next frame. It provokes the second by moving chip select and the serial clock at the same instant, and expects the pad released one cycle later with no extra bit shifted. The cycle-accurate model in the bench judges both cases on every clock.

// File: rtl/adcsdo_pkg.sv
package adcsdo_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_WAIT_FS = 2'd1,
      ST_SHIFT   = 2'd2,
      ST_DONE    = 2'd3
   } port_state_e;
endpackage

// File: rtl/adcsdo_sync.sv
module adcsdo_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic prev_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("adcsdo_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RESET_VAL}};
         prev_q  <= RESET_VAL;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign prev_o  = prev_q;
endmodule

// File: rtl/adcsdo_shift.sv
module adcsdo_shift #(
   parameter int RESULT_W = 14,
   parameter int FRAME_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                store_i,
   input  logic [RESULT_W-1:0] store_word_i,
   input  logic                start_i,
   input  logic                shift_i,
   output logic                msb_o
);
   localparam int PAD_W = FRAME_W - RESULT_W;

   if (FRAME_W < RESULT_W || RESULT_W < 1) begin : g_bad_widths
      $error("adcsdo_shift: FRAME_W must be at least RESULT_W");
   end

   logic [RESULT_W-1:0] word_q;
   logic [FRAME_W-1:0]  frame_q;
   logic [FRAME_W-1:0]  frame_init;

   if (PAD_W == 0) begin : g_nopad
      assign frame_init = word_q;
   end else begin : g_pad
      assign frame_init = {word_q, {PAD_W{1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (store_i) begin
         word_q <= store_word_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
      end else if (start_i) begin
         frame_q <= frame_init;
      end else if (shift_i) begin
         frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
      end
   end

   assign msb_o = frame_q[FRAME_W-1];

   AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !shift_i) |=> $stable(frame_q)); // R5
   AST_LOAD_NO_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
      (store_i && !start_i && !shift_i) |=> $stable(msb_o)); // R8
endmodule

// File: rtl/adcsdo_ctrl.sv
module adcsdo_ctrl
   import adcsdo_pkg::*;
#(
   parameter int FRAME_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_level_i,
   input  logic cs_fall_i,
   input  logic fs_level_i,
   input  logic fs_rise_i,
   input  logic sclk_rise_i,
   output logic start_o,
   output logic shift_o,
   output logic drive_o
);
   localparam int END_CNT = FRAME_W + 1;
   localparam int CNT_W   = $clog2(END_CNT + 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(END_CNT - 1);
   localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(END_CNT);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("adcsdo_ctrl: FRAME_W must be at least 2");
   end

   port_state_e      state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      if (cs_level_i) begin
         state_d = ST_IDLE;
         cnt_d   = '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (cs_fall_i) begin
                  state_d = fs_level_i ? ST_SHIFT : ST_WAIT_FS;
                  cnt_d   = '0;
               end
            end
            ST_WAIT_FS: begin
               if (fs_rise_i) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
               if (sclk_rise_i) begin
                  if (cnt_q == LAST_CNT) begin
                     state_d = ST_DONE;
                     cnt_d   = DONE_CNT;
                  end else begin
                     cnt_d = cnt_q + 1'b1;
                  end
               end
            end
            default: state_d = ST_DONE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign start_o = (state_q == ST_IDLE) && !cs_level_i && cs_fall_i;
   assign shift_o = (state_q == ST_SHIFT) && !cs_level_i && sclk_rise_i && (cnt_q != LAST_CNT);
   assign drive_o = (state_q == ST_SHIFT);

   AST_CS_HIGH_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      cs_level_i |=> !drive_o); // R1
   AST_CS_MODE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (start_o && fs_level_i) |=> drive_o); // R2
   AST_FS_MODE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (start_o && !fs_level_i) |=> (!drive_o && state_q == ST_WAIT_FS)); // R3
   AST_LAST_EDGE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_o && !cs_level_i && sclk_rise_i && cnt_q == LAST_CNT) |=> !drive_o); // R6
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= DONE_CNT); // R6
   AST_CS_OVER_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_level_i && sclk_rise_i) |=> (cnt_q == '0 && !drive_o)); // R9
endmodule

// File: rtl/adcsdo_port.sv
module adcsdo_port #(
   parameter int RESULT_W    = 14,
   parameter int FRAME_W     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n_i,
   input  logic                fs_i,
   input  logic                sclk_i,
   input  logic [RESULT_W-1:0] result_i,
   input  logic                load_i,
   output logic                sdo_o,
   output logic                sdo_oe_o
);
   logic cs_lvl, cs_prev, fs_lvl, fs_prev, sc_lvl, sc_prev;
   logic cs_fall, fs_rise, sc_rise;
   logic start, shift, drive, msb;

   adcsdo_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(cs_n_i), .level_o(cs_lvl), .prev_o(cs_prev));
   adcsdo_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_fs_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(fs_i), .level_o(fs_lvl), .prev_o(fs_prev));
   adcsdo_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sclk_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(sclk_i), .level_o(sc_lvl), .prev_o(sc_prev));

   assign cs_fall = !cs_lvl && cs_prev;
   assign fs_rise = fs_lvl && !fs_prev;
   assign sc_rise = sc_lvl && !sc_prev;

   adcsdo_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cs_level_i(cs_lvl), .cs_fall_i(cs_fall),
      .fs_level_i(fs_lvl), .fs_rise_i(fs_rise),
      .sclk_rise_i(sc_rise),
      .start_o(start), .shift_o(shift), .drive_o(drive));

   adcsdo_shift #(.RESULT_W(RESULT_W), .FRAME_W(FRAME_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .store_i(load_i), .store_word_i(result_i),
      .start_i(start), .shift_i(shift), .msb_o(msb));

   assign sdo_oe_o = drive;
   assign sdo_o    = drive & msb;

   AST_START_FROM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (!cs_lvl && cs_prev)); // R2
   AST_IDLE_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe_o |-> !sdo_o); // R1
endmodule

// File: tb/adcsdo_port_tb.sv
module adcsdo_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        fs = 1'b1;
   logic        sclk = 1'b0;
   logic [13:0] result = '0;
   logic        load = 1'b0;
   logic        sdo, sdo_oe;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string cur_tag = "R1";

   always #4 clk = ~clk;

   adcsdo_port dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .fs_i(fs), .sclk_i(sclk),
      .result_i(result), .load_i(load), .sdo_o(sdo), .sdo_oe_o(sdo_oe));

   // reference model: pin history, abstract frame state
   logic [3:0]  h_cs, h_fs, h_sc;
   int          m_state;   // 0 idle, 1 waiting for frame-sync, 2 shifting, 3 finished
   int          m_rises;
   logic [15:0] m_frame;
   logic [13:0] m_word;

   always @(posedge clk) begin
      if (!rst_n) begin
         h_cs = 4'hF; h_fs = 4'hF; h_sc = 4'h0;
         m_state = 0; m_rises = 0; m_frame = '0; m_word = '0;
      end else begin
         h_cs = {h_cs[2:0], cs_n};
         h_fs = {h_fs[2:0], fs};
         h_sc = {h_sc[2:0], sclk};
         if (h_cs[2]) begin
            m_state = 0; m_rises = 0;
         end else if (m_state == 0) begin
            if (h_cs[3]) begin
               m_frame = {m_word, 2'b00};
               m_rises = 0;
               m_state = h_fs[2] ? 2 : 1;
            end
         end else if (m_state == 1) begin
            if (h_fs[2] && !h_fs[3]) m_state = 2;
         end else if (m_state == 2) begin
            if (h_sc[2] && !h_sc[3]) begin
               m_rises++;
               if (m_rises == 17) m_state = 3;
               else m_frame = m_frame << 1;
            end
         end
         if (load) m_word = result;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(sdo_oe == (m_state == 2), cur_tag, "model oe", int'(sdo_oe), int'(m_state == 2));
         chk(sdo == ((m_state == 2) & m_frame[15]), cur_tag, "model sdo",
             int'(sdo), int'((m_state == 2) & m_frame[15]));
      end
   end

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_load(input logic [13:0] w);
      @(negedge clk);
      result = w; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic run_frame(input bit fs_mode, input int nclk, input logic [13:0] exp_word,
                            input string tag, input bit mid_load, input logic [13:0] mid_word,
                            input bit coll_load, input logic [13:0] coll_word);
      logic [15:0] got;
      got = '0;
      cur_tag = tag;
      fs = fs_mode ? 1'b0 : 1'b1;
      wait_n(2);
      cs_n = 1'b0;
      if (coll_load) begin
         @(negedge clk);
         @(negedge clk);
         result = coll_word; load = 1'b1;
         @(negedge clk);
         load = 1'b0;
         wait_n(3);
      end else begin
         wait_n(6);
      end
      if (fs_mode) begin
         chk(sdo_oe == 1'b0, "R3", "oe before frame-sync", int'(sdo_oe), 0);
         sclk = 1'b1; wait_n(4);
         sclk = 1'b0; wait_n(4);
         chk(sdo_oe == 1'b0, "R3", "oe after early clock", int'(sdo_oe), 0);
         fs = 1'b1; wait_n(5);
      end
      chk(sdo_oe == 1'b1, fs_mode ? "R3" : "R2", "oe at data start", int'(sdo_oe), 1);
      got[15] = sdo;
      for (int k = 1; k <= nclk; k++) begin
         sclk = 1'b1;
         if (mid_load && k == 8) begin
            @(negedge clk);
            result = mid_word; load = 1'b1;
            @(negedge clk);
            load = 1'b0;
            wait_n(2);
         end else begin
            wait_n(4);
         end
         if (k <= 15) got[15-k] = sdo;
         if (k == 16) chk(sdo_oe == 1'b1 && sdo == 1'b0, "R5", "zero after 16 clocks", int'({sdo_oe, sdo}), 2);
         if (k == 17) chk(sdo_oe == 1'b0, "R6", "float after 17th edge", int'(sdo_oe), 0);
         sclk = 1'b0;
         wait_n(4);
      end
      chk(got == {exp_word, 2'b00}, tag, "host word", int'(got), int'({exp_word, 2'b00}));
      if (nclk < 17) chk(sdo_oe == 1'b1, "R7", "still driving before cs rise", int'(sdo_oe), 1);
      cs_n = 1'b1;
      wait_n(4);
      chk(sdo_oe == 1'b0, "R7", "float after cs rise", int'(sdo_oe), 0);
      fs = 1'b1;
      wait_n(3);
   endtask

   initial begin
      wait_n(3);
      chk(sdo_oe == 1'b0 && sdo == 1'b0, "R1", "reset outputs", int'({sdo_oe, sdo}), 0);
      rst_n = 1'b1;
      wait_n(3);
      chk(sdo_oe == 1'b0, "R1", "idle after reset", int'(sdo_oe), 0);

      do_load(14'h2A5B);
      run_frame(1'b0, 16, 14'h2A5B, "R4", 1'b0, '0, 1'b0, '0);
      do_load(14'h3C0F);
      run_frame(1'b0, 20, 14'h3C0F, "R6", 1'b0, '0, 1'b0, '0);
      do_load(14'h0F0F);
      run_frame(1'b1, 17, 14'h0F0F, "R3", 1'b0, '0, 1'b0, '0);
      do_load(14'h1234);
      run_frame(1'b0, 17, 14'h1234, "R8", 1'b1, 14'h0ABC, 1'b0, '0);
      run_frame(1'b1, 16, 14'h0ABC, "R8", 1'b0, '0, 1'b0, '0);
      do_load(14'h1111);
      run_frame(1'b0, 16, 14'h1111, "R9", 1'b0, '0, 1'b1, 14'h2222);
      run_frame(1'b0, 17, 14'h2222, "R9", 1'b0, '0, 1'b0, '0);
      do_load(14'h3FFF);
      run_frame(1'b0, 17, 14'h3FFF, "R5", 1'b0, '0, 1'b0, '0);

      // R10: latency from chip-select pin to pad enable
      cur_tag = "R10";
      do_load(14'h0001);
      cs_n = 1'b0;
      @(negedge clk);
      chk(sdo_oe == 1'b0, "R10", "oe one edge after cs", int'(sdo_oe), 0);
      @(negedge clk);
      chk(sdo_oe == 1'b0, "R10", "oe two edges after cs", int'(sdo_oe), 0);
      @(negedge clk);
      chk(sdo_oe == 1'b1, "R10", "oe three edges after cs", int'(sdo_oe), 1);
      for (int k = 0; k < 10; k++) begin
         sclk = 1'b1; wait_n(4);
         sclk = 1'b0; wait_n(4);
      end
      // R9: chip-select rise together with a serial-clock rise
      cur_tag = "R9";
      sclk = 1'b1; cs_n = 1'b1;
      wait_n(4);
      chk(sdo_oe == 1'b0, "R9", "cs rise beats clock", int'(sdo_oe), 0);
      sclk = 1'b0;
      wait_n(4);
      do_load(14'h2AAA);
      run_frame(1'b0, 17, 14'h2AAA, "R9", 1'b0, '0, 1'b0, '0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 200000; i++) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule